// File: doc/BRIEF.md
# SDRAM Command Front End with Clock Suspend

This block sits at the pin side of a four-bank, 32-bit-wide synchronous DRAM. On every rising clock edge it samples the active-low chip select, row strobe, column strobe and write strobe. It also samples the clock enable, an 11-bit multiplexed address and a 2-bit bank select. From these it produces one registered strobe for each command type. It records which banks hold an open row. It latches the row, column and bank for the array logic behind it.

The block also runs a small burst tracker. A tracker advances through the columns of a read or write burst. It stops on a burst-stop command and ignores idle commands.

A low clock enable takes the block out of its run state. If any bank is open, the block enters clock suspend. If no bank is open, it enters power-down. In either state new commands are ignored and the burst tracker freezes. Entry and exit each take effect one edge after the clock enable is sampled.

Top module: `sdram_cmd_front`

## Requirements
- R1: With chip select low and the row, column and write strobes all high at an accepted edge, `nop_o` pulses high for the cycle after that edge and no other strobe rises.
- R2: With chip select low at an accepted edge, the strobes {row, column, write} decode as follows. 0,1,1 gives `act_o`. 1,0,1 gives `rd_o`. 1,0,0 gives `wr_o`. 0,1,0 gives `pre_o` when address bit 10 is low, and `pre_all_o` when it is high. 1,1,0 gives `bst_o`. 0,0,1 gives `ref_o`. 0,0,0 gives `mrs_o`. At most one strobe output is high in any cycle.
- R3: Chip select high at an edge raises no strobe, whatever the other strobes are. Neither that nor a no-operation ends or alters a running burst.
- R4: In the run state, clock enable sampled low at an edge enters clock suspend (`suspend_o`) if the open-bank set after that edge is non-empty, counting a command accepted on the same edge. Otherwise it enters power-down (`power_down_o`). The two flags are never high together.
- R5: The command on the entry edge is still accepted. On every later edge while suspended or powered down, commands are ignored: no strobe rises, and `open_banks_o`, `row_o`, `col_o` and `bank_o` hold.
- R6: Clock enable sampled high while suspended or powered down returns the block to run after that edge. The command on that edge is still ignored, and a command on the next edge is accepted.
- R7: `open_banks_o` (bit n = bank n) is set by an accepted activate, cleared for one bank by a precharge and cleared entirely by a precharge-all.
- R8: An accepted activate loads `row_o` with the full address and `bank_o` with the bank select. An accepted read or write loads `col_o` with address bits 7:0 and `bank_o` with the bank select. A single-bank precharge also loads `bank_o`.
- R9: An accepted read or write starts a burst of 4 cycles. `burst_busy_o` is high from the cycle after the command, and `burst_col_o` starts at the command's column. It advances by one per accepted edge, wrapping within its aligned group of 4. A burst stop clears `burst_busy_o` after its edge.
- R10: On edges where commands are ignored, `burst_busy_o` and `burst_col_o` hold their values.
- R11: After reset every strobe is low, `open_banks_o` is zero, the block is in run and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock, rising edge samples |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| cke_i | input | 1 | Clock enable |
| addr_i | input | 11 | Multiplexed row/column address; bit 10 picks precharge scope |
| bank_i | input | 2 | Bank select |
| nop_o | output | 1 | No-operation decoded |
| act_o | output | 1 | Activate decoded |
| rd_o | output | 1 | Read decoded |
| wr_o | output | 1 | Write decoded |
| pre_o | output | 1 | Single-bank precharge decoded |
| pre_all_o | output | 1 | All-bank precharge decoded |
| bst_o | output | 1 | Burst stop decoded |
| ref_o | output | 1 | Refresh decoded |
| mrs_o | output | 1 | Mode-register set decoded |
| bank_o | output | 2 | Latched bank of last activate/read/write/precharge |
| row_o | output | 11 | Latched row address |
| col_o | output | 8 | Latched column address |
| open_banks_o | output | 4 | Open-bank set |
| suspend_o | output | 1 | Clock suspend active |
| power_down_o | output | 1 | Power-down active |
| burst_busy_o | output | 1 | Burst in progress |
| burst_col_o | output | 8 | Current burst column |

## Verification
Two things can meet on one edge: a command that changes the open-bank set, and a falling clock enable. Together they decide whether the block suspends or powers down. The bench drives an activate with clock enable low while all banks are closed, and expects `act_o` together with `suspend_o`, not `power_down_o`. It also drives a precharge-all with clock enable low while banks are open, and expects power-down. A burst overlapping a suspend is judged by the burst column holding through the frozen edges and then resuming at the next column.

// File: rtl/sdram_fe_pkg.sv
package sdram_fe_pkg;
  typedef enum logic [3:0] {
    CMD_NONE, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR,
    CMD_PRE, CMD_PREA, CMD_BST, CMD_REF, CMD_MRS
  } cmd_e;

  typedef enum logic [1:0] {MODE_RUN, MODE_SUSP, MODE_PDN} mode_e;

  typedef struct packed {
    logic nop;
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic pre_all;
    logic bst;
    logic refr;
    logic mrs;
  } strobe_t;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_fe_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic ap_i,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NONE;
    if (!cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b111: cmd_o = CMD_NOP;
        3'b011: cmd_o = CMD_ACT;
        3'b101: cmd_o = CMD_RD;
        3'b100: cmd_o = CMD_WR;
        3'b010: cmd_o = ap_i ? CMD_PREA : CMD_PRE;
        3'b110: cmd_o = CMD_BST;
        3'b001: cmd_o = CMD_REF;
        3'b000: cmd_o = CMD_MRS;
        default: cmd_o = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_fe_pkg::*;
#(
  parameter int BANKS  = 4,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [BANKS-1:0]  open_q_o,
  output logic [BANKS-1:0]  open_nx_o
);
  always_comb begin
    open_nx_o = open_q_o;
    case (cmd_i)
      CMD_ACT:  open_nx_o[bank_i] = 1'b1;
      CMD_PRE:  open_nx_o[bank_i] = 1'b0;
      CMD_PREA: open_nx_o = '0;
      default:  ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_q_o <= '0;
    else         open_q_o <= open_nx_o;
  end
endmodule

// File: rtl/sdram_power_ctrl.sv
module sdram_power_ctrl
  import sdram_fe_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cke_i,
  input  logic  any_open_i,
  output mode_e mode_o,
  output logic  accept_o
);
  mode_e mode_nx;

  always_comb begin
    mode_nx = mode_o;
    unique case (mode_o)
      MODE_RUN: if (!cke_i) mode_nx = any_open_i ? MODE_SUSP : MODE_PDN;
      MODE_SUSP,
      MODE_PDN: if (cke_i) mode_nx = MODE_RUN;
      default:  mode_nx = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_o <= MODE_RUN;
    else         mode_o <= mode_nx;
  end

  // mode seen at this edge reflects CKE from the previous edge: one-cycle entry/exit delay
  assign accept_o = (mode_o == MODE_RUN);
endmodule

// File: rtl/sdram_burst_tracker.sv
module sdram_burst_tracker #(
  parameter int COL_W     = 8,
  parameter int BURST_LEN = 4,
  localparam int BL_W     = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             hold_i,
  input  logic [COL_W-1:0] col_i,
  output logic             busy_o,
  output logic [COL_W-1:0] col_o
);
  logic [BL_W-1:0]  left_q;
  logic [BL_W-1:0]  lo_inc;
  logic [COL_W-1:0] col_step;

  assign lo_inc = col_o[BL_W-1:0] + BL_W'(1);

  generate
    if (COL_W > BL_W) begin : g_wrap
      assign col_step = {col_o[COL_W-1:BL_W], lo_inc};
    end else begin : g_full
      assign col_step = lo_inc[COL_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      left_q <= '0;
      col_o  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      left_q <= BL_W'(BURST_LEN - 1);
      col_o  <= col_i;
    end else if (stop_i) begin
      busy_o <= 1'b0;
    end else if (busy_o && !hold_i) begin
      if (left_q == '0) begin
        busy_o <= 1'b0;
      end else begin
        left_q <= left_q - BL_W'(1);
        col_o  <= col_step;
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdram_fe_pkg::*;
#(
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int BANKS     = 4,
  parameter int BURST_LEN = 4,
  parameter int AP_BIT    = 10,
  localparam int BANK_W   = $clog2(BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              cke_i,
  input  logic [ROW_W-1:0]  addr_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              nop_o,
  output logic              act_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              pre_o,
  output logic              pre_all_o,
  output logic              bst_o,
  output logic              ref_o,
  output logic              mrs_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [BANKS-1:0]  open_banks_o,
  output logic              suspend_o,
  output logic              power_down_o,
  output logic              burst_busy_o,
  output logic [COL_W-1:0]  burst_col_o
);
  cmd_e             cmd_raw, cmd_acc;
  logic             accept;
  mode_e            mode;
  logic [BANKS-1:0] open_nx;
  strobe_t          stb_q;

  sdram_cmd_decode u_dec (
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .ap_i   (addr_i[AP_BIT]),
    .cmd_o  (cmd_raw)
  );

  assign cmd_acc = accept ? cmd_raw : CMD_NONE;

  sdram_bank_tracker #(.BANKS(BANKS)) u_banks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd_acc),
    .bank_i    (bank_i),
    .open_q_o  (open_banks_o),
    .open_nx_o (open_nx)
  );

  sdram_power_ctrl u_pwr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cke_i      (cke_i),
    .any_open_i (|open_nx),
    .mode_o     (mode),
    .accept_o   (accept)
  );

  sdram_burst_tracker #(.COL_W(COL_W), .BURST_LEN(BURST_LEN)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cmd_acc == CMD_RD || cmd_acc == CMD_WR),
    .stop_i  (cmd_acc == CMD_BST),
    .hold_i  (!accept),
    .col_i   (addr_i[COL_W-1:0]),
    .busy_o  (burst_busy_o),
    .col_o   (burst_col_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= '0;
    end else begin
      stb_q <= '0;
      case (cmd_acc)
        CMD_NOP:  stb_q.nop     <= 1'b1;
        CMD_ACT:  stb_q.act     <= 1'b1;
        CMD_RD:   stb_q.rd      <= 1'b1;
        CMD_WR:   stb_q.wr      <= 1'b1;
        CMD_PRE:  stb_q.pre     <= 1'b1;
        CMD_PREA: stb_q.pre_all <= 1'b1;
        CMD_BST:  stb_q.bst     <= 1'b1;
        CMD_REF:  stb_q.refr    <= 1'b1;
        CMD_MRS:  stb_q.mrs     <= 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o  <= '0;
      col_o  <= '0;
      bank_o <= '0;
    end else begin
      if (cmd_acc == CMD_ACT) begin
        row_o  <= addr_i;
        bank_o <= bank_i;
      end
      if (cmd_acc == CMD_RD || cmd_acc == CMD_WR) begin
        col_o  <= addr_i[COL_W-1:0];
        bank_o <= bank_i;
      end
      if (cmd_acc == CMD_PRE) bank_o <= bank_i;
    end
  end

  assign nop_o        = stb_q.nop;
  assign act_o        = stb_q.act;
  assign rd_o         = stb_q.rd;
  assign wr_o         = stb_q.wr;
  assign pre_o        = stb_q.pre;
  assign pre_all_o    = stb_q.pre_all;
  assign bst_o        = stb_q.bst;
  assign ref_o        = stb_q.refr;
  assign mrs_o        = stb_q.mrs;
  assign suspend_o    = (mode == MODE_SUSP);
  assign power_down_o = (mode == MODE_PDN);
endmodule

// File: rtl/sdram_cmd_front_chk.sv
module sdram_cmd_front_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       cke_i,
  input logic       nop_o,
  input logic       act_o,
  input logic       rd_o,
  input logic       wr_o,
  input logic       pre_o,
  input logic       pre_all_o,
  input logic       bst_o,
  input logic       ref_o,
  input logic       mrs_o,
  input logic [3:0] open_banks_o,
  input logic       suspend_o,
  input logic       power_down_o,
  input logic       burst_busy_o,
  input logic [7:0] burst_col_o
);
  logic [8:0] stb;
  logic       idle_mode;
  assign stb = {nop_o, act_o, rd_o, wr_o, pre_o, pre_all_o, bst_o, ref_o, mrs_o};
  assign idle_mode = suspend_o || power_down_o;

  assert_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb));

  assert_deselect_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (stb == 9'd0));

  assert_enter_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_mode && !cke_i) |=> idle_mode);

  assert_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(suspend_o && power_down_o));

  assert_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_mode |=> (stb == 9'd0));

  assert_banks_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_mode |=> $stable(open_banks_o));

  assert_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_mode && cke_i) |=> !idle_mode);

  assert_prea_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_all_o |-> (open_banks_o == 4'd0));

  assert_bst_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bst_o |-> !burst_busy_o);

  assert_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_mode |=> ($stable(burst_col_o) && $stable(burst_busy_o)));
endmodule

bind sdram_cmd_front sdram_cmd_front_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_ni        (cs_ni),
  .cke_i        (cke_i),
  .nop_o        (nop_o),
  .act_o        (act_o),
  .rd_o         (rd_o),
  .wr_o         (wr_o),
  .pre_o        (pre_o),
  .pre_all_o    (pre_all_o),
  .bst_o        (bst_o),
  .ref_o        (ref_o),
  .mrs_o        (mrs_o),
  .open_banks_o (open_banks_o),
  .suspend_o    (suspend_o),
  .power_down_o (power_down_o),
  .burst_busy_o (burst_busy_o),
  .burst_col_o  (burst_col_o)
);

// File: tb/tb_sdram_cmd_front.sv
module tb_sdram_cmd_front;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic        cke_i = 1'b1;
  logic [10:0] addr_i = '0;
  logic [1:0]  bank_i = '0;
  logic nop_o, act_o, rd_o, wr_o, pre_o, pre_all_o, bst_o, ref_o, mrs_o;
  logic [1:0]  bank_o;
  logic [10:0] row_o;
  logic [7:0]  col_o;
  logic [3:0]  open_banks_o;
  logic        suspend_o, power_down_o, burst_busy_o;
  logic [7:0]  burst_col_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // strobe bit order: nop act rd wr pre pre_all bst ref mrs
  localparam logic [8:0] S_NOP = 9'h100, S_ACT = 9'h080, S_RD = 9'h040, S_WR = 9'h020,
                         S_PRE = 9'h010, S_PREA = 9'h008, S_BST = 9'h004,
                         S_REF = 9'h002, S_MRS = 9'h001;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sdram_cmd_front dut (.*);

  function automatic logic [8:0] stb();
    return {nop_o, act_o, rd_o, wr_o, pre_o, pre_all_o, bst_o, ref_o, mrs_o};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one edge; return just after it with registered outputs settled
  task automatic cyc(input logic cs, input logic ras, input logic cas, input logic we,
                     input logic cke, input logic [10:0] a, input logic [1:0] b);
    @(negedge clk_i);
    cs_ni = cs; ras_ni = ras; cas_ni = cas; we_ni = we; cke_i = cke;
    addr_i = a; bank_i = b;
    @(posedge clk_i);
    #1;
  endtask

  task automatic nop(input logic cke = 1'b1);
    cyc(0, 1, 1, 1, cke, 11'd0, 2'd0);
  endtask

  task automatic t_reset();
    chk("R11 strobes", 32'(stb()), 0);
    chk("R11 open", 32'(open_banks_o), 0);
    chk("R11 mode", {30'd0, suspend_o, power_down_o}, 0);
    chk("R11 burst", 32'(burst_busy_o), 0);
  endtask

  task automatic t_decode();
    nop();                         chk("R1 nop", 32'(stb()), 32'(S_NOP));
    chk("R1 no state", 32'(open_banks_o), 0);
    cyc(0, 0, 1, 1, 1, 11'h001, 0); chk("R2 act", 32'(stb()), 32'(S_ACT));
    cyc(0, 1, 0, 1, 1, 11'h004, 0); chk("R2 rd", 32'(stb()), 32'(S_RD));
    cyc(0, 1, 0, 0, 1, 11'h008, 0); chk("R2 wr", 32'(stb()), 32'(S_WR));
    cyc(0, 1, 1, 0, 1, 11'h000, 0); chk("R2 bst", 32'(stb()), 32'(S_BST));
    cyc(0, 0, 0, 1, 1, 11'h000, 0); chk("R2 ref", 32'(stb()), 32'(S_REF));
    cyc(0, 0, 0, 0, 1, 11'h033, 0); chk("R2 mrs", 32'(stb()), 32'(S_MRS));
    cyc(0, 0, 1, 0, 1, 11'h000, 0); chk("R2 pre", 32'(stb()), 32'(S_PRE));
    cyc(0, 0, 1, 0, 1, 11'h400, 0); chk("R2 pre_all", 32'(stb()), 32'(S_PREA));
    cyc(1, 0, 0, 0, 1, 11'h400, 1); chk("R3 deselect", 32'(stb()), 0);
  endtask

  task automatic t_banks();
    cyc(0, 0, 1, 1, 1, 11'h5A3, 2);
    chk("R7 act2", 32'(open_banks_o), 32'h4);
    chk("R8 row", 32'(row_o), 32'h5A3);
    chk("R8 bank", 32'(bank_o), 2);
    cyc(0, 0, 1, 1, 1, 11'h011, 0); chk("R7 act0", 32'(open_banks_o), 32'h5);
    cyc(0, 0, 1, 0, 1, 11'h000, 2); chk("R7 pre2", 32'(open_banks_o), 32'h1);
    cyc(0, 0, 1, 1, 1, 11'h022, 3); chk("R7 act3", 32'(open_banks_o), 32'h9);
    cyc(0, 0, 1, 0, 1, 11'h400, 1); chk("R7 prea", 32'(open_banks_o), 0);
  endtask

  task automatic t_burst();
    cyc(0, 1, 0, 1, 1, 11'h036, 1);
    chk("R8 col", 32'(col_o), 32'h36);
    chk("R8 rd bank", 32'(bank_o), 1);
    chk("R9 busy", 32'(burst_busy_o), 1);
    chk("R9 col0", 32'(burst_col_o), 32'h36);
    nop();                          chk("R9 col1", 32'(burst_col_o), 32'h37);
    cyc(1, 0, 0, 0, 1, 11'h000, 0); chk("R3 wrap under deselect", 32'(burst_col_o), 32'h34);
    nop();                          chk("R9 col3", 32'(burst_col_o), 32'h35);
    chk("R3 still busy", 32'(burst_busy_o), 1);
    nop();                          chk("R9 end", 32'(burst_busy_o), 0);
    cyc(0, 1, 0, 0, 1, 11'h010, 0); chk("R9 wr busy", 32'(burst_busy_o), 1);
    cyc(0, 1, 1, 0, 1, 11'h000, 0); chk("R9 bst ends", 32'(burst_busy_o), 0);
  endtask

  task automatic t_suspend();
    cyc(0, 0, 1, 1, 1, 11'h100, 1);
    cyc(0, 1, 0, 1, 1, 11'h020, 1); chk("R9 start", 32'(burst_col_o), 32'h20);
    nop(1'b0);
    chk("R4 suspend", {30'd0, suspend_o, power_down_o}, 32'h2);
    chk("R5 entry edge accepted", 32'(stb()), 32'(S_NOP));
    chk("R10 advanced on entry", 32'(burst_col_o), 32'h21);
    cyc(0, 0, 1, 1, 0, 11'h0AA, 3);
    chk("R5 ignored", 32'(stb()), 0);
    chk("R5 banks held", 32'(open_banks_o), 32'h2);
    chk("R5 row held", 32'(row_o), 32'h100);
    chk("R10 col frozen", 32'(burst_col_o), 32'h21);
    cyc(0, 0, 1, 1, 1, 11'h0AA, 3);
    chk("R6 exit edge ignored", 32'(stb()), 0);
    chk("R6 run", 32'(suspend_o), 0);
    chk("R10 still frozen", 32'(burst_col_o), 32'h21);
    nop();
    chk("R6 accepted", 32'(stb()), 32'(S_NOP));
    chk("R10 resumes", 32'(burst_col_o), 32'h22);
    cyc(0, 0, 1, 1, 1, 11'h0AA, 3); chk("R7 act3 after exit", 32'(open_banks_o), 32'hA);
    cyc(0, 0, 1, 0, 1, 11'h400, 0);
    nop(); nop();
  endtask

  task automatic t_pdown();
    nop(1'b0);
    chk("R4 power down", {30'd0, suspend_o, power_down_o}, 32'h1);
    cyc(0, 0, 1, 1, 0, 11'h000, 0);
    chk("R5 pd ignored", 32'(stb()), 0);
    chk("R5 pd banks", 32'(open_banks_o), 0);
    nop();
    chk("R6 pd exit", {30'd0, suspend_o, power_down_o}, 0);
    cyc(0, 0, 1, 1, 1, 11'h000, 0); chk("R6 pd accepted", 32'(open_banks_o), 32'h1);
  endtask

  task automatic t_same_edge();
    cyc(0, 0, 1, 0, 1, 11'h400, 0);
    cyc(0, 0, 1, 1, 0, 11'h07F, 2);
    chk("R4 same-edge act", 32'(stb()), 32'(S_ACT));
    chk("R4 same-edge suspend", {30'd0, suspend_o, power_down_o}, 32'h2);
    nop();
    chk("R6 same-edge exit ignored", 32'(stb()), 0);
    cyc(0, 0, 1, 0, 0, 11'h400, 0);
    chk("R4 prea low cke", 32'(stb()), 32'(S_PREA));
    chk("R4 prea -> pd", {30'd0, suspend_o, power_down_o}, 32'h1);
    nop();
    nop();
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_decode();
    t_banks();
    t_burst();
    t_suspend();
    t_pdown();
    t_same_edge();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule